// File: doc/BRIEF.md
# I2C Register-Access Target for a 16-bit Port Expander

This block is the serial front end of a 16-bit port expander. It watches an I2C bus through SCL and SDA samples that have already been synchronised to a fast system clock. It pulls SDA low through an open-drain enable. It recognises its own 7-bit target address, which is formed from three strap inputs. Each strap pin can be tied to ground, supply, SCL or SDA, so 32 addresses are possible.

After the address, a command byte loads a register pointer that selects one of 22 byte-wide registers. Writes reach the port logic as a one-cycle strobe that carries the pointer and the data byte. For a read, the master sends a repeated start with the read bit set. The block then fetches bytes through a combinational read port and shifts them out MSB first until the master declines with a NACK.

The pointer toggles between the two halves of a register pair after every data byte. Long transfers therefore alternate between port 1 and port 2 of the same function.

Top module: `i2c_regport_slave`

## Requirements
- R1: Strap codes are 0=GND, 1=VCC, 2=tied to SCL, 3=tied to SDA. Bit 1 of the A1 and A0 codes selects the 8-bit address base: both clear gives 0x40, only A1 set gives 0x20, both set gives 0x30, only A0 set gives 0x50. Bit 0 of the A2, A1 and A0 codes adds 0x08, 0x04 and 0x02 to that base. Bit 0 of the 8-bit address is the R/W bit, where 1 means read. A matching address byte is acknowledged.
- R2: SDA falling while SCL is high starts a new address phase from any state. SDA rising while SCL is high returns the block to idle. A new transaction works after a start that was followed at once by a stop.
- R3: An acknowledge holds sda_oe high from the falling edge after bit 8 until the falling edge after the ninth clock. A non-matching address is not acknowledged, and every later byte is ignored (no ack, no strobe) until the next start.
- R4: A command byte of 0x00 to 0x15 is acknowledged and loads the pointer. A command byte above 0x15 is not acknowledged, and the following bytes produce no strobe and no ack.
- R5: Every data byte of a write is acknowledged. For a writable pointer, reg_wr pulses for exactly one cycle with reg_addr equal to the pointer and reg_wdata equal to the byte. Offsets 0x00, 0x01, 0x0E and 0x0F give no reg_wr, and no strobe ever carries an offset above 0x15.
- R6: After each data byte, in either direction, pointer bit 0 inverts (0x0A becomes 0x0B, and 0x0B becomes 0x0A). The pointer persists across transactions, so a read without a command byte continues from it.
- R7: In a read, the byte at the pointer is sent MSB first, with sda_oe equal to the inverse of each bit. A master ACK fetches the next byte. A master NACK ends the transfer, and the block releases SDA.
- R8: Each byte fetched for transmit gives one single-cycle reg_rd pulse while reg_addr still shows the fetched offset. stat_rd pulses with it only when that offset is 0x00 or 0x01. reg_wr and reg_rd never pulse together.
- R9: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample |
| strap_a2 | input | 2 | Strap code of address pin A2 |
| strap_a1 | input | 2 | Strap code of address pin A1 |
| strap_a0 | input | 2 | Strap code of address pin A0 |
| sda_oe | output | 1 | Pull SDA low when high |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_addr | output | 5 | Register pointer (offset) |
| reg_wdata | output | 8 | Write data byte |
| reg_rd | output | 1 | One-cycle strobe: byte fetched for transmit |
| stat_rd | output | 1 | One-cycle strobe: state register fetched |
| reg_rdata | input | 8 | Read data for reg_addr, combinational |

## Verification
One SCL falling edge does two jobs at the end of the address acknowledge in a read. It releases the acknowledge, and in the same system cycle it drives bit 7 of the first read byte. When that bit is 0, sda_oe has to stay asserted across the handover, and when it is 1, sda_oe has to drop. The bench reads registers whose top bits differ, so both cases occur. It judges them by the bytes the master samples during SCL high, and by a monitor that flags any sda_oe change while SCL is high.

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave #(
  parameter int NREG = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_a2,
  input  logic [1:0] strap_a1,
  input  logic [1:0] strap_a0,
  output logic       sda_oe,
  output logic       reg_wr,
  output logic [4:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_rd,
  output logic       stat_rd,
  input  logic [7:0] reg_rdata
);

  localparam logic [7:0] LAST_OFF = 8'(NREG - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK, S_WDAT, S_WACK, S_RDAT, S_MACK
  } st_t;

  st_t        st;
  logic       scl_q, sda_q;
  logic [2:0] bitcnt;
  logic [7:0] sr, tx;
  logic [4:0] ptr;
  logic       ack_on, ack_ok, rw, mst_ack;

  logic       scl_rise, scl_fall, start_c, stop_c, ptr_ro;
  logic [7:0] rx_byte;
  logic [3:0] hi4;
  logic [6:0] my_addr;

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  assign rx_byte  = {sr[6:0], sda_i};
  assign reg_addr = ptr;
  assign ptr_ro   = (ptr[4:1] == 4'd0) || (ptr[4:1] == 4'd7);

  always_comb begin
    case ({strap_a1[1], strap_a0[1]})
      2'b00:   hi4 = 4'b0100;
      2'b10:   hi4 = 4'b0010;
      2'b11:   hi4 = 4'b0011;
      default: hi4 = 4'b0101;
    endcase
  end
  assign my_addr = {hi4, strap_a2[0], strap_a1[0], strap_a0[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; scl_q <= 1'b1; sda_q <= 1'b1;
      bitcnt <= '0; sr <= '0; tx <= '0; ptr <= '0;
      ack_on <= 1'b0; ack_ok <= 1'b0; rw <= 1'b0; mst_ack <= 1'b0;
      sda_oe <= 1'b0; reg_wr <= 1'b0; reg_wdata <= '0;
      reg_rd <= 1'b0; stat_rd <= 1'b0;
    end else begin
      scl_q   <= scl_i;
      sda_q   <= sda_i;
      reg_wr  <= 1'b0;
      reg_rd  <= 1'b0;
      stat_rd <= 1'b0;
      if (start_c) begin
        st <= S_ADDR; bitcnt <= '0; sda_oe <= 1'b0; ack_on <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0; ack_on <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_CMD, S_WDAT: if (scl_rise) begin
            sr     <= rx_byte;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              ack_on <= 1'b0;
              case (st)
                S_ADDR: begin
                  ack_ok <= (rx_byte[7:1] == my_addr);
                  rw     <= rx_byte[0];
                  st     <= S_AACK;
                end
                S_CMD: begin
                  ack_ok <= (rx_byte <= LAST_OFF);
                  if (rx_byte <= LAST_OFF) ptr <= rx_byte[4:0];
                  st <= S_CACK;
                end
                default: begin
                  ack_ok <= 1'b1;
                  if (!ptr_ro) begin
                    reg_wr    <= 1'b1;
                    reg_wdata <= rx_byte;
                  end
                  st <= S_WACK;
                end
              endcase
            end
          end
          S_AACK, S_CACK, S_WACK: if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;
              sda_oe <= ack_ok;
            end else begin
              ack_on <= 1'b0;
              sda_oe <= 1'b0;
              bitcnt <= '0;
              if (!ack_ok) st <= S_IDLE;
              else begin
                case (st)
                  S_AACK: begin
                    if (rw) begin
                      st      <= S_RDAT;
                      tx      <= reg_rdata;
                      sda_oe  <= ~reg_rdata[7];
                      reg_rd  <= 1'b1;
                      stat_rd <= (ptr[4:1] == 4'd0);
                    end else begin
                      st <= S_CMD;
                    end
                  end
                  S_CACK:  st <= S_WDAT;
                  default: begin
                    st     <= S_WDAT;
                    ptr[0] <= ~ptr[0];
                  end
                endcase
              end
            end
          end
          S_RDAT: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_oe  <= 1'b0;
              mst_ack <= 1'b0;
              ptr[0]  <= ~ptr[0];
              st      <= S_MACK;
            end else begin
              bitcnt <= bitcnt + 3'd1;
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end
          end
          S_MACK: begin
            if (scl_rise) mst_ack <= ~sda_i;
            else if (scl_fall) begin
              bitcnt <= '0;
              if (mst_ack) begin
                st      <= S_RDAT;
                tx      <= reg_rdata;
                sda_oe  <= ~reg_rdata[7];
                reg_rd  <= 1'b1;
                stat_rd <= (ptr[4:1] == 4'd0);
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_regport_slave_chk.sv
module i2c_regport_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       reg_wr,
  input logic [4:0] reg_addr,
  input logic       reg_rd,
  input logic       stat_rd
);

  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_i));

  // R5
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (reg_addr != 5'h00 && reg_addr != 5'h01 &&
                reg_addr != 5'h0E && reg_addr != 5'h0F && reg_addr <= 5'h15));

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R8
  stat_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> (reg_rd && reg_addr[4:1] == 4'd0));

  // R8
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  // R8
  no_wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

endmodule

bind i2c_regport_slave i2c_regport_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_rd(reg_rd), .stat_rd(stat_rd)
);

// File: tb/i2c_regport_slave_bench.sv
module i2c_regport_slave_bench;
  localparam int H = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sdam = 1'b1;
  logic [1:0] s2 = 2'd0, s1 = 2'd0, s0 = 2'd0;
  logic       sda_oe, reg_wr, reg_rd, stat_rd;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sda_bus;
  logic [7:0] model [32];

  assign sda_bus   = sdam & ~sda_oe;
  assign reg_rdata = model[reg_addr];

  i2c_regport_slave u_i2c_regport_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_a2(s2), .strap_a1(s1), .strap_a0(s0),
    .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .stat_rd(stat_rd),
    .reg_rdata(reg_rdata)
  );

  int n_chk = 0, n_bad = 0, n_rd = 0, n_srd = 0, oe_viol = 0;
  logic oe_prev = 1'b0, scl_prev = 1'b1;
  logic [12:0] exp_q [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (reg_wr) begin
      if (exp_q.size() == 0) check(0, "R5 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        check({reg_addr, reg_wdata} == e, "R5/R6 write strobe", {reg_addr, reg_wdata}, e);
        model[reg_addr] = reg_wdata;
      end
    end
    if (reg_rd) n_rd++;
    if (stat_rd) n_srd++;
    if (sda_oe != oe_prev && scl_prev) oe_viol++;
    oe_prev  = sda_oe;
    scl_prev = scl_m;
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #3; end
  endtask

  task automatic bus_start();
    tick(2); sdam = 1'b1; tick(H); scl_m = 1'b1; tick(H);
    sdam = 1'b0; tick(H); scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    tick(2); sdam = 1'b0; tick(H); scl_m = 1'b1; tick(H); sdam = 1'b1; tick(H);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(2); sdam = b[i]; tick(H - 2); scl_m = 1'b1; tick(H); scl_m = 1'b0;
    end
    tick(2); sdam = 1'b1; tick(H - 2); scl_m = 1'b1; tick(H / 2);
    ack = ~sda_bus; tick(H / 2); scl_m = 1'b0;
  endtask

  task automatic recv(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(2); sdam = 1'b1; tick(H - 2); scl_m = 1'b1; tick(H / 2);
      b[i] = sda_bus; tick(H / 2); scl_m = 1'b0;
    end
    tick(2); sdam = nack; tick(H - 2); scl_m = 1'b1; tick(H); scl_m = 1'b0;
    tick(2); sdam = 1'b1;
  endtask

  function automatic logic [6:0] exp_addr(input logic [1:0] a2, input logic [1:0] a1, input logic [1:0] a0);
    int v;
    bit b1, b0;
    b1 = (a1 >= 2); b0 = (a0 >= 2);
    if (!b1 && !b0) v = 'h40;
    else if (b1 && !b0) v = 'h20;
    else if (b1 && b0) v = 'h30;
    else v = 'h50;
    if (a2 == 2'd1) v += 8;
    if ((b1 && a1 == 2'd3) || (!b1 && a1 == 2'd1)) v += 4;
    if ((b0 && a0 == 2'd3) || (!b0 && a0 == 2'd1)) v += 2;
    return 7'(v >> 1);
  endfunction

  logic [6:0] me;

  task automatic wr_txn(input logic [7:0] cmd, input int nbytes, input logic [7:0] d0, input bit ro);
    logic a;
    logic [4:0] p;
    p = cmd[4:0];
    bus_start();
    send({me, 1'b0}, a); check(a == 1'b1, "R1 address ack", a, 1);
    send(cmd, a);        check(a == 1'b1, "R4 command ack", a, 1);
    for (int k = 0; k < nbytes; k++) begin
      if (!ro) exp_q.push_back({p, 8'(d0 + k)});
      send(8'(d0 + k), a); check(a == 1'b1, "R5 data ack", a, 1);
      p[0] = ~p[0];
    end
    bus_stop();
  endtask

  task automatic rd_txn(input bit use_cmd, input logic [7:0] cmd, input int nbytes,
                        input logic [4:0] first, input int exp_srd);
    logic a;
    logic [7:0] b;
    logic [4:0] p;
    int rd0, srd0;
    p = first; rd0 = n_rd; srd0 = n_srd;
    bus_start();
    if (use_cmd) begin
      send({me, 1'b0}, a); check(a == 1'b1, "R1 address ack", a, 1);
      send(cmd, a);        check(a == 1'b1, "R4 command ack", a, 1);
      bus_start();
    end
    send({me, 1'b1}, a); check(a == 1'b1, "R7 read address ack", a, 1);
    for (int k = 0; k < nbytes; k++) begin
      recv(k == nbytes - 1, b);
      check(b == model[p], "R7/R6 read byte", b, model[p]);
      p[0] = ~p[0];
    end
    bus_stop();
    check(n_rd - rd0 == nbytes, "R8 reg_rd count", n_rd - rd0, nbytes);
    check(n_srd - srd0 == exp_srd, "R8 stat_rd count", n_srd - srd0, exp_srd);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    logic a;
    for (int i = 0; i < 32; i++) model[i] = 8'(i * 37 + 5);
    tick(5);
    check(sda_oe == 1'b0, "R3 reset sda_oe", sda_oe, 0);
    check(reg_wr == 1'b0 && reg_rd == 1'b0, "R8 reset strobes", {reg_wr, reg_rd}, 0);
    rst_n = 1'b1;
    tick(5);

    // R1: one strap combination from each address range
    begin
      logic [5:0] combos [4];
      combos[0] = {2'd1, 2'd0, 2'd1};
      combos[1] = {2'd0, 2'd3, 2'd1};
      combos[2] = {2'd1, 2'd2, 2'd3};
      combos[3] = {2'd0, 2'd1, 2'd2};
      for (int c = 0; c < 4; c++) begin
        {s2, s1, s0} = combos[c];
        me = exp_addr(s2, s1, s0);
        tick(4);
        wr_txn(8'h06, 1, 8'(8'h30 + c), 1'b0);
      end
    end

    // R3: wrong address, every later byte ignored
    bus_start();
    send({me ^ 7'h01, 1'b0}, a); check(a == 1'b0, "R3 mismatch nack", a, 0);
    send(8'h02, a);              check(a == 1'b0, "R3 ignored cmd", a, 0);
    send(8'h55, a);              check(a == 1'b0, "R3 ignored data", a, 0);
    bus_stop();

    // R4: command above 0x15
    bus_start();
    send({me, 1'b0}, a); check(a == 1'b1, "R4 address ack", a, 1);
    send(8'h16, a);      check(a == 1'b0, "R4 bad command nack", a, 0);
    send(8'hAA, a);      check(a == 1'b0, "R4 data ignored", a, 0);
    bus_stop();

    // R6: pair toggling on writes
    wr_txn(8'h0A, 3, 8'h81, 1'b0);
    // R5: read-only offsets take no write
    wr_txn(8'h0E, 2, 8'h11, 1'b1);
    wr_txn(8'h00, 2, 8'h22, 1'b1);

    // R2: start followed by stop, then a normal write
    bus_start();
    bus_stop();
    wr_txn(8'h15, 1, 8'h7E, 1'b0);

    // R7, R6, R8: reads; both MSB values occur on the first byte
    rd_txn(1'b1, 8'h0B, 3, 5'h0B, 0);
    rd_txn(1'b1, 8'h01, 2, 5'h01, 2);
    rd_txn(1'b1, 8'h12, 1, 5'h12, 0);
    // R6: no command, pointer continues (0x12 became 0x13)
    rd_txn(1'b0, 8'h00, 2, 5'h13, 0);

    tick(20);
    check(oe_viol == 0, "R9 sda_oe change with SCL high", oe_viol, 0);
    check(exp_q.size() == 0, "R5 missing writes", exp_q.size(), 0);
    summary();
  end
endmodule